// File: doc/BRIEF.md
# Eight-Pin Multi-Mode I/O Controller

This block sits between a processor's register bus and eight pad cells. Every pin has a two-bit drive mode: push-pull output, input, open-drain or open-source. The value a pin drives comes from one of two places. The first is a bit of the output-data register. The second is a per-pin three-bit selector over eight shared peripheral signals. Three write-only strobe registers let software set, clear or invert single output bits without a read-modify-write.

Pad input passes through a two-flop synchronizer. The synchronized value can be read only for pins whose input buffer is switched on; other pins read 0. The mode storage can be written as a whole, or one half at a time through two alias registers, so four pins can be reconfigured without touching the other four.

Registers are 32 bits wide and sit at consecutive word addresses:

| Word | Register |
|---|---|
| 0 | mode |
| 1 | input enable |
| 2 | source select |
| 3 | data out |
| 4 | data in |
| 5 | set strobe |
| 6 | clear strobe |
| 7 | toggle strobe |
| 8 to 15 | selector for pins 0 to 7 |
| 16 | mode alias, low half |
| 17 | mode alias, high half |

Top module: `pin_mode_ctrl`

## Requirements
- R1: After reset every register reads 0. All pins are then in push-pull mode driving 0, so pad_oe=FFh, pad_out=00h, pad_pull_ok=00h and pad_ie=00h.
- R2: Pin n's mode sits at bits [2n+1:2n] of the mode register (word 0). The low alias (word 16) reads and writes pins 0-3 as bits [7:0]. The high alias (word 17) does the same for pins 4-7. Both aliases share storage with word 0.
- R3: In mode 0 (push-pull) the pin drives: pad_oe=1, pad_out equals the selected value, and pad_pull_ok=0.
- R4: In mode 1 (input) the pin is released: pad_oe=0, pad_out=0 and pad_pull_ok=1.
- R5: In mode 2 (open-drain) a selected value of 0 gives pad_oe=1 and pad_out=0. A selected value of 1 gives pad_oe=0 and pad_pull_ok=1. pad_oe and pad_pull_ok are never both 1 in any mode.
- R6: In mode 3 (open-source) a selected value of 1 gives pad_oe=1 and pad_out=1. A selected value of 0 gives pad_oe=0, pad_out=0 and pad_pull_ok=1.
- R7: When source-select bit n (word 2) is 0, pin n's selected value is data-out bit n (word 3). When the bit is 1, the selected value comes from the pin's selector.
- R8: The selector for pin n (word 8+n, bits [2:0]) holding k picks periph_src[k]. The index order is: 0 event observation, 1 SPI clock, 2 SPI data out, 3-6 timer events 0-3, 7 timer pulse.
- R9: Writing 1 to bit n of word 5, 6 or 7 sets, clears or inverts data-out bit n. Bits written as 0 are left unchanged. All three words read 0.
- R10: Word 4 bit n returns pad_in[n] after two synchronizer clock edges when input-enable bit n (word 1) is 1, and 0 when that bit is 0.
- R11: pad_ie[n] follows input-enable bit n in every mode.
- R12: Bits above each field read 0. Writes to unlisted words change nothing, and reads of those words return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_addr | input | 7 | Byte address (bits [1:0] ignored) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| periph_src | input | 8 | Shared peripheral signals, indexed by the selectors |
| pad_in | input | 8 | Asynchronous pad input levels |
| pad_out | output | 8 | Value driven onto each pad |
| pad_oe | output | 8 | Pad driver enable |
| pad_pull_ok | output | 8 | Pin released; a pull may act |
| pad_ie | output | 8 | Digital input buffer enable |

## Verification
The bench sweeps all 256 output-data values under every uniform mode and under two mixed mode layouts. A swapped mode decode, or a reversed open-drain or open-source polarity, therefore shows up on pad_oe and pad_out. Every selector value is driven against one-hot peripheral patterns, which catches a selector that indexes the wrong source or reads a neighbour pin's field. The strobe tests write 0 bits that must leave data-out untouched, and expose a strobe that overwrites the whole register or reads back nonzero. The data-in test reads after one edge and then after two; a single-flop path, or one that ignores input enable, returns the pad value too early or ungated.

// File: rtl/pin_ctrl_pkg.sv
package pin_ctrl_pkg;
    localparam int N_PINS     = 8;
    localparam int N_SRC      = 8;
    localparam int SEL_W      = $clog2(N_SRC);
    localparam int MODE_W     = 2;
    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 7;
    localparam int WORD_W     = ADDR_W - 2;
    localparam int HALF_PINS  = N_PINS / 2;
    localparam int MODE_BITS  = MODE_W * N_PINS;
    localparam int ALIAS_BITS = MODE_W * HALF_PINS;

    typedef logic [WORD_W-1:0] word_t;

    localparam word_t W_MODE    = word_t'(0);
    localparam word_t W_INEN    = word_t'(1);
    localparam word_t W_SRCSEL  = word_t'(2);
    localparam word_t W_DOUT    = word_t'(3);
    localparam word_t W_DIN     = word_t'(4);
    localparam word_t W_SET     = word_t'(5);
    localparam word_t W_CLR     = word_t'(6);
    localparam word_t W_TGL     = word_t'(7);
    localparam word_t W_PSEL0   = word_t'(8);
    localparam word_t W_MODE_LO = word_t'(8 + N_PINS);
    localparam word_t W_MODE_HI = word_t'(9 + N_PINS);

    typedef enum logic [MODE_W-1:0] {
        PM_PUSH   = 2'd0,
        PM_INPUT  = 2'd1,
        PM_ODRAIN = 2'd2,
        PM_OSRC   = 2'd3
    } pin_mode_e;

    typedef struct packed {
        logic [MODE_BITS-1:0]           mode;
        logic [N_PINS-1:0]              in_en;
        logic [N_PINS-1:0]              use_periph;
        logic [N_PINS-1:0]              dout;
        logic [N_PINS-1:0][SEL_W-1:0]   psel;
    } pin_cfg_t;
endpackage

// File: rtl/pin_in_sync.sv
module pin_in_sync
    import pin_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pad_in,
    output logic [N_PINS-1:0] din_sync
);
    typedef struct packed {
        logic [N_PINS-1:0] s1;
        logic [N_PINS-1:0] s2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = pad_in;
        sync_d.s2 = sync_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign din_sync = sync_q.s2;
endmodule

// File: rtl/pin_drive.sv
module pin_drive
    import pin_ctrl_pkg::*;
(
    input  pin_mode_e         mode,
    input  logic              use_periph,
    input  logic              dout_bit,
    input  logic [SEL_W-1:0]  psel,
    input  logic [N_SRC-1:0]  periph_src,
    output logic              drv,
    output logic              oe,
    output logic              pull_ok
);
    logic val;

    always_comb begin
        val     = use_periph ? periph_src[psel] : dout_bit;
        drv     = 1'b0;
        oe      = 1'b0;
        pull_ok = 1'b0;
        case (mode)
            PM_PUSH: begin
                oe  = 1'b1;
                drv = val;
            end
            PM_INPUT: begin
                pull_ok = 1'b1;
            end
            PM_ODRAIN: begin
                oe      = ~val;
                pull_ok = val;
            end
            PM_OSRC: begin
                oe      = val;
                drv     = val;
                pull_ok = ~val;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pin_ctrl_regs.sv
module pin_ctrl_regs
    import pin_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [N_PINS-1:0] din_sync,
    output logic [DATA_W-1:0] rdata,
    output pin_cfg_t          cfg
);
    pin_cfg_t cfg_d, cfg_q;
    word_t    widx;
    logic     unused_bits;

    assign widx        = addr[ADDR_W-1:2];
    assign unused_bits = ^{addr[1:0], wdata[DATA_W-1:MODE_BITS]};

    // next-state for all configuration storage
    always_comb begin
        cfg_d = cfg_q;
        if (wr) begin
            case (widx)
                W_MODE:    cfg_d.mode       = wdata[MODE_BITS-1:0];
                W_INEN:    cfg_d.in_en      = wdata[N_PINS-1:0];
                W_SRCSEL:  cfg_d.use_periph = wdata[N_PINS-1:0];
                W_DOUT:    cfg_d.dout       = wdata[N_PINS-1:0];
                W_SET:     cfg_d.dout       = cfg_q.dout | wdata[N_PINS-1:0];
                W_CLR:     cfg_d.dout       = cfg_q.dout & ~wdata[N_PINS-1:0];
                W_TGL:     cfg_d.dout       = cfg_q.dout ^ wdata[N_PINS-1:0];
                W_MODE_LO: cfg_d.mode[ALIAS_BITS-1:0] = wdata[ALIAS_BITS-1:0];
                W_MODE_HI: cfg_d.mode[MODE_BITS-1:ALIAS_BITS] = wdata[ALIAS_BITS-1:0];
                default: ;
            endcase
            for (int k = 0; k < N_PINS; k++) begin
                if (widx == word_t'(int'(W_PSEL0) + k))
                    cfg_d.psel[k] = wdata[SEL_W-1:0];
            end
        end
    end

    // read mux; strobes and unlisted words return zero
    always_comb begin
        rdata = '0;
        case (widx)
            W_MODE:    rdata[MODE_BITS-1:0]  = cfg_q.mode;
            W_INEN:    rdata[N_PINS-1:0]     = cfg_q.in_en;
            W_SRCSEL:  rdata[N_PINS-1:0]     = cfg_q.use_periph;
            W_DOUT:    rdata[N_PINS-1:0]     = cfg_q.dout;
            W_DIN:     rdata[N_PINS-1:0]     = din_sync & cfg_q.in_en;
            W_MODE_LO: rdata[ALIAS_BITS-1:0] = cfg_q.mode[ALIAS_BITS-1:0];
            W_MODE_HI: rdata[ALIAS_BITS-1:0] = cfg_q.mode[MODE_BITS-1:ALIAS_BITS];
            default: ;
        endcase
        for (int k = 0; k < N_PINS; k++) begin
            if (widx == word_t'(int'(W_PSEL0) + k))
                rdata[SEL_W-1:0] = cfg_q.psel[k];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/pin_mode_ctrl.sv
module pin_mode_ctrl
    import pin_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [N_SRC-1:0]  periph_src,
    input  logic [N_PINS-1:0] pad_in,
    output logic [N_PINS-1:0] pad_out,
    output logic [N_PINS-1:0] pad_oe,
    output logic [N_PINS-1:0] pad_pull_ok,
    output logic [N_PINS-1:0] pad_ie
);
    pin_cfg_t             cfg;
    logic [N_PINS-1:0]    din_sync;
    logic [MODE_BITS-1:0] cfg_mode;
    logic [N_PINS-1:0]    cfg_dout;
    logic [N_PINS-1:0]    cfg_in_en;

    pin_in_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pad_in   (pad_in),
        .din_sync (din_sync)
    );

    pin_ctrl_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .din_sync (din_sync),
        .rdata    (reg_rdata),
        .cfg      (cfg)
    );

    assign cfg_mode  = cfg.mode;
    assign cfg_dout  = cfg.dout;
    assign cfg_in_en = cfg.in_en;
    assign pad_ie    = cfg.in_en;

    for (genvar g = 0; g < N_PINS; g++) begin : g_pin
        pin_drive u_drv (
            .mode       (pin_mode_e'(cfg.mode[MODE_W*g +: MODE_W])),
            .use_periph (cfg.use_periph[g]),
            .dout_bit   (cfg.dout[g]),
            .psel       (cfg.psel[g]),
            .periph_src (periph_src),
            .drv        (pad_out[g]),
            .oe         (pad_oe[g]),
            .pull_ok    (pad_pull_ok[g])
        );
    end
endmodule

// File: rtl/pin_ctrl_checker.sv
module pin_ctrl_checker
    import pin_ctrl_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 reg_wr,
    input logic [ADDR_W-1:0]    reg_addr,
    input logic [DATA_W-1:0]    reg_wdata,
    input logic [DATA_W-1:0]    reg_rdata,
    input logic [N_PINS-1:0]    pad_out,
    input logic [N_PINS-1:0]    pad_oe,
    input logic [N_PINS-1:0]    pad_pull_ok,
    input logic [MODE_BITS-1:0] cfg_mode,
    input logic [N_PINS-1:0]    cfg_dout,
    input logic [N_PINS-1:0]    cfg_in_en
);
    word_t             widx;
    logic [N_PINS-1:0] wbits;
    assign widx  = reg_addr[ADDR_W-1:2];
    assign wbits = reg_wdata[N_PINS-1:0];

    a_r5_oe_pull_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & pad_pull_ok) == '0);

    a_r4_released_low: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_out & ~pad_oe) == '0);

    a_r9_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && widx == W_SET) |=> ((cfg_dout & $past(wbits)) == $past(wbits)));

    a_r9_clr_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && widx == W_CLR) |=> ((cfg_dout & $past(wbits)) == '0));

    a_r9_tgl_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && widx == W_TGL) |=> (cfg_dout == ($past(cfg_dout) ^ $past(wbits))));

    a_r2_alias_low: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && widx == W_MODE_LO) |=>
        (cfg_mode[ALIAS_BITS-1:0] == $past(reg_wdata[ALIAS_BITS-1:0]) &&
         cfg_mode[MODE_BITS-1:ALIAS_BITS] == $past(cfg_mode[MODE_BITS-1:ALIAS_BITS])));

    a_r12_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && widx > W_MODE_HI) |=>
        ($stable(cfg_mode) && $stable(cfg_dout) && $stable(cfg_in_en)));

    a_r10_din_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (widx == W_DIN) |->
        ((reg_rdata[N_PINS-1:0] & ~cfg_in_en) == '0 && reg_rdata[DATA_W-1:N_PINS] == '0));
endmodule

bind pin_mode_ctrl pin_ctrl_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .pad_out     (pad_out),
    .pad_oe      (pad_oe),
    .pad_pull_ok (pad_pull_ok),
    .cfg_mode    (cfg_mode),
    .cfg_dout    (cfg_dout),
    .cfg_in_en   (cfg_in_en)
);

// File: tb/test_pin_mode_ctrl.sv
`timescale 1ns/1ps
module test_pin_mode_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [6:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  periph_src = '0;
    logic [7:0]  pad_in = '0;
    logic [7:0]  pad_out, pad_oe, pad_pull_ok, pad_ie;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model of software-visible state
    logic [15:0]     m_mode = '0;
    logic [7:0]      m_src  = '0;
    logic [7:0]      m_dout = '0;
    logic [7:0][2:0] m_psel = '0;

    always #2.5 clk = ~clk;

    pin_mode_ctrl i_pin_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .periph_src(periph_src),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_pull_ok(pad_pull_ok), .pad_ie(pad_ie)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input int word, input logic [31:0] d);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_addr  = 7'(word * 4);
        reg_wdata = d;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input int word, output logic [31:0] d);
        @(negedge clk);
        reg_addr = 7'(word * 4);
        #1 d = reg_rdata;
    endtask

    task automatic set_mode(input logic [15:0] m);
        m_mode = m;
        wr(0, {16'h0, m});
    endtask

    task automatic set_src(input logic [7:0] s);
        m_src = s;
        wr(2, {24'h0, s});
    endtask

    task automatic set_dout(input logic [7:0] v);
        m_dout = v;
        wr(3, {24'h0, v});
    endtask

    task automatic set_psel(input int k, input logic [2:0] s);
        m_psel[k] = s;
        wr(8 + k, {29'h0, s});
    endtask

    // expected pad behaviour from the mode and source requirements
    task automatic check_pins(input string tag);
        logic [7:0] e_out, e_oe, e_pull;
        for (int k = 0; k < 8; k++) begin
            logic v;
            v = m_src[k] ? periph_src[m_psel[k]] : m_dout[k];
            case (m_mode[2*k +: 2])
                2'd0: begin e_oe[k] = 1'b1; e_out[k] = v;    e_pull[k] = 1'b0; end
                2'd1: begin e_oe[k] = 1'b0; e_out[k] = 1'b0; e_pull[k] = 1'b1; end
                2'd2: begin e_oe[k] = ~v;   e_out[k] = 1'b0; e_pull[k] = v;    end
                default: begin e_oe[k] = v; e_out[k] = v;    e_pull[k] = ~v;   end
            endcase
        end
        #1;
        chk({tag, " pad_oe"},      {24'h0, pad_oe},      {24'h0, e_oe});
        chk({tag, " pad_out"},     {24'h0, pad_out},     {24'h0, e_out});
        chk({tag, " pad_pull_ok"}, {24'h0, pad_pull_ok}, {24'h0, e_pull});
    endtask

    function automatic logic [15:0] rep_mode(input logic [1:0] m);
        logic [15:0] r;
        for (int k = 0; k < 8; k++) r[2*k +: 2] = m;
        return r;
    endfunction

    initial begin
        logic [31:0] d;
        string tags[4];
        tags[0] = "R3"; tags[1] = "R4"; tags[2] = "R5"; tags[3] = "R6";

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int w = 0; w < 18; w++) begin
            rd(w, d);
            chk($sformatf("R1 word %0d", w), d, 32'h0);
        end
        chk("R1 pad_oe", {24'h0, pad_oe}, 32'hFF);
        chk("R1 pad_out", {24'h0, pad_out}, 32'h0);
        chk("R1 pad_pull_ok", {24'h0, pad_pull_ok}, 32'h0);
        chk("R1 pad_ie", {24'h0, pad_ie}, 32'h0);

        // R2 / R12: mode layout, aliases, reserved bits
        wr(0, 32'hFFFF_FFFF);
        rd(0, d); chk("R12 mode reserved", d, 32'h0000_FFFF);
        wr(0, 32'h0000_A5C3);
        rd(16, d); chk("R2 low alias read", d, 32'hC3);
        rd(17, d); chk("R2 high alias read", d, 32'hA5);
        wr(16, 32'hFFFF_FF1B);
        rd(0, d); chk("R2 low alias write", d, 32'hA51B);
        wr(17, 32'h0000_016E);
        rd(0, d); chk("R2 high alias write", d, 32'h6E1B);
        rd(16, d); chk("R12 alias reserved", d, 32'h1B);
        wr(8, 32'hFFFF_FFFF);
        rd(8, d); chk("R12 selector reserved", d, 32'h7);
        wr(8, 32'h0);

        // R3-R6 with R7 data-out path: all dout values under uniform modes
        for (int m = 0; m < 4; m++) begin
            set_mode(rep_mode(2'(m)));
            set_src(8'h00);
            for (int v = 0; v < 256; v++) begin
                set_dout(8'(v));
                check_pins({tags[m], " R7 dout"});
            end
        end
        // mixed layouts
        for (int p = 0; p < 2; p++) begin
            set_mode(p == 0 ? 16'hE4E4 : 16'h1B1B);
            for (int v = 0; v < 256; v++) begin
                set_dout(8'(v));
                check_pins("R3 R4 R5 R6 mixed");
            end
        end

        // R7/R8: peripheral path, each selector value against one-hot sources
        set_mode(16'h0000);
        set_src(8'hFF);
        for (int s = 0; s < 8; s++) begin
            for (int k = 0; k < 8; k++) set_psel(k, 3'(s + k));
            for (int b = 0; b < 8; b++) begin
                @(negedge clk); periph_src = 8'(1 << b);
                check_pins("R8 selector");
                @(negedge clk); periph_src = ~8'(1 << b);
                check_pins("R8 selector inv");
            end
        end
        for (int k = 0; k < 8; k++) begin
            rd(8 + k, d); chk("R8 selector readback", d, {29'h0, m_psel[k]});
        end
        // half from peripherals, half from data out, open-drain and open-source
        set_src(8'h5A);
        set_mode(16'hAFFA);
        for (int v = 0; v < 256; v++) begin
            @(negedge clk); periph_src = 8'(v * 37);
            set_dout(8'(v));
            check_pins("R7 source mix");
        end

        // R9: strobes
        set_src(8'h00);
        set_dout(8'h5A);
        wr(5, 32'h81);  m_dout = 8'hDB;
        rd(3, d); chk("R9 set", d, 32'hDB);
        wr(6, 32'h0F);  m_dout = 8'hD0;
        rd(3, d); chk("R9 clear", d, 32'hD0);
        wr(7, 32'hFF);  m_dout = 8'h2F;
        rd(3, d); chk("R9 toggle", d, 32'h2F);
        wr(5, 32'h0); wr(6, 32'h0); wr(7, 32'h0);
        rd(3, d); chk("R9 zero bits no effect", d, 32'h2F);
        check_pins("R9 pins follow strobes");
        for (int w = 5; w < 8; w++) begin
            rd(w, d); chk("R9 strobe reads zero", d, 32'h0);
        end

        // R10 / R11: synchronized, gated input
        set_mode(16'h5555);
        wr(1, 32'hF0);
        #1 chk("R11 pad_ie", {24'h0, pad_ie}, 32'hF0);
        @(negedge clk); pad_in = 8'hFF;
        rd(4, d); chk("R10 one edge not yet", d, 32'h0);
        rd(4, d); chk("R10 two edges gated", d, 32'hF0);
        wr(1, 32'h3C);
        rd(4, d); chk("R10 enable change", d, 32'h3C);
        @(negedge clk); pad_in = 8'h00;
        rd(4, d); rd(4, d); chk("R10 falls", d, 32'h0);
        wr(1, 32'h00);
        #1 chk("R11 pad_ie off", {24'h0, pad_ie}, 32'h0);

        // R12: unlisted words
        wr(18, 32'hFFFF_FFFF);
        wr(31, 32'hFFFF_FFFF);
        rd(18, d); chk("R12 unlisted read", d, 32'h0);
        rd(31, d); chk("R12 unlisted read top", d, 32'h0);
        rd(0, d);  chk("R12 mode untouched", d, 32'h5555);
        rd(3, d);  chk("R12 dout untouched", d, 32'h2F);
        rd(1, d);  chk("R12 in_en untouched", d, 32'h0);
        check_pins("R12 pins untouched");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule